// File: doc/BRIEF.md
# Synchronous Dual-Ratio Clock Divider

This block takes one input clock and derives two slower clocks from it. The first runs at half the input rate. The second runs at a quarter or a sixth of the input rate, picked by a select input. Both come from flip-flops on the same rising input edge, so wherever the two outputs rise in the same input period, they rise together. A third output pulses high for one input period on each such shared rise. System logic can use it to line up other stages with the divided clocks.

Division is gated by an enable input. That input is registered on the falling input edge. The gating acts as a count enable on the rising-edge flip-flops and never as a gated clock, so starting or stopping the dividers cannot shorten any pulse. An asynchronous, active-high master reset puts every divider flip-flop into a known state. Several copies released from the same reset therefore run in lockstep.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: On every rising input edge at which the registered enable is high, `half_clk_o` toggles, giving a 50% duty clock at half the input rate.
- R2: While enabled, `slow_clk_o` has a period of 4 input cycles (high 2, low 2) when `ratio_sel_i` = 0 and 6 input cycles (high 3, low 3) when `ratio_sel_i` = 1.
- R3: `slow_clk_o` rises only on an edge where `half_clk_o` also rises.
- R4: The enable value used at a rising edge is the one captured at the preceding falling edge. A pulse on `run_i` that starts after a falling edge and ends before the next falling edge has no effect. A drop of `run_i` after a falling edge still lets the next rising edge advance.
- R5: While the registered enable is low, both divided outputs hold their level. When enable returns, counting resumes from the held state.
- R6: `mark_o` is high for exactly one input period, following each edge where both `half_clk_o` and `slow_clk_o` rise, and is low at all other times.
- R7: `ratio_sel_i` is sampled only at the edge that starts a new `slow_clk_o` period (its rising edge). A period already in progress completes at the old ratio.
- R8: While `rst_i` is high, all three outputs are low, even between clock edges. After release, the first rising edge that follows a falling edge with `run_i` high drives `half_clk_o`, `slow_clk_o` and `mark_o` high together.
- R9: The registered enable resets to off. After reset release with `run_i` low, all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_i | input | 1 | Asynchronous master reset, active high |
| run_i | input | 1 | Enable, registered on the falling edge of `clk_i` |
| ratio_sel_i | input | 1 | Ratio select for `slow_clk_o`: 0 = divide by 4, 1 = divide by 6 |
| half_clk_o | output | 1 | Input clock divided by 2 |
| slow_clk_o | output | 1 | Input clock divided by 4 or 6 |
| mark_o | output | 1 | One-period pulse on common rising edges |

## Verification
The divider runs through long stretches at each ratio, and each cycle is compared with a period-counting model. This separates a wrong period from a wrong duty cycle, and either from a `mark_o` that fires off the shared edges. Some ratio switches land mid-period and others land at a wrap, which shows whether the select is applied early. Disabled stretches in the middle of a period show that the state is held and resumed rather than restarted. Enable pulses placed on each side of the falling edge show which edge samples `run_i`.

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv #(
  parameter int unsigned RATIO_LO = 4,
  parameter int unsigned RATIO_HI = 6
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic ratio_sel_i,
  output logic half_clk_o,
  output logic slow_clk_o,
  output logic mark_o
);
  localparam int unsigned CW = $clog2(RATIO_HI);
  localparam logic [CW-1:0] LAST_LO = CW'(RATIO_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(RATIO_HI - 1);
  localparam logic [CW-1:0] HALF_LO = CW'(RATIO_LO / 2);
  localparam logic [CW-1:0] HALF_HI = CW'(RATIO_HI / 2);

  logic          run_q;
  logic          sel_q;
  logic [CW-1:0] pos_q;

  wire          wrap   = pos_q == (sel_q ? LAST_HI : LAST_LO);
  wire          sel_nx = wrap ? ratio_sel_i : sel_q;
  wire [CW-1:0] pos_nx = wrap ? '0 : pos_q + CW'(1);
  wire          slow_nx = pos_nx < (sel_nx ? HALF_HI : HALF_LO);

  always_ff @(negedge clk_i or posedge rst_i)
    if (rst_i) run_q <= 1'b0;
    else       run_q <= run_i;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      half_clk_o <= 1'b0;
      slow_clk_o <= 1'b0;
      mark_o     <= 1'b0;
      sel_q      <= 1'b0;
      pos_q      <= LAST_LO;
    end else begin
      mark_o <= run_q & ~half_clk_o & ~slow_clk_o & slow_nx;
      if (run_q) begin
        half_clk_o <= ~half_clk_o;
        slow_clk_o <= slow_nx;
        sel_q      <= sel_nx;
        pos_q      <= pos_nx;
      end
    end
  end
endmodule

// File: rtl/dual_ratio_clkdiv_chk.sv
module dual_ratio_clkdiv_chk (
  input logic clk_i,
  input logic rst_i,
  input logic run_q,
  input logic half_clk_o,
  input logic slow_clk_o,
  input logic mark_o
);
  AST_HALF_TOGGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    run_q |=> half_clk_o != $past(half_clk_o)); // R1
  AST_SLOW_ALIGNED: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(slow_clk_o) |-> $rose(half_clk_o)); // R3
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_q |=> $stable(half_clk_o) && $stable(slow_clk_o)); // R5
  AST_MARK_ON_COMMON: assert property (@(posedge clk_i) disable iff (rst_i)
    mark_o |-> $rose(half_clk_o) && $rose(slow_clk_o)); // R6
  AST_COMMON_GIVES_MARK: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(half_clk_o) && $rose(slow_clk_o)) |-> mark_o); // R6
  AST_MARK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    mark_o |=> !mark_o); // R6
  AST_RESET_LOW: assert property (@(posedge clk_i)
    rst_i |-> !half_clk_o && !slow_clk_o && !mark_o); // R8
endmodule

bind dual_ratio_clkdiv dual_ratio_clkdiv_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .run_q(run_q),
  .half_clk_o(half_clk_o), .slow_clk_o(slow_clk_o), .mark_o(mark_o)
);

// File: tb/dual_ratio_clkdiv_tb.sv
module dual_ratio_clkdiv_tb;
  logic clk = 1'b0, rst = 1'b1, run = 1'b0, sel = 1'b0;
  logic half_clk, slow_clk, mark;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_ratio_clkdiv u_dut (.clk_i(clk), .rst_i(rst), .run_i(run), .ratio_sel_i(sel),
    .half_clk_o(half_clk), .slow_clk_o(slow_clk), .mark_o(mark));

  // {run, sel, cycles, sel-change segment}
  localparam logic [10:0] SEG [0:8] = '{
    {1'b1, 1'b0, 8'd12, 1'b0}, {1'b1, 1'b1, 8'd2, 1'b1}, {1'b1, 1'b1, 8'd12, 1'b0},
    {1'b0, 1'b1, 8'd5,  1'b0}, {1'b1, 1'b1, 8'd7, 1'b0}, {1'b1, 1'b0, 8'd3,  1'b1},
    {1'b1, 1'b0, 8'd10, 1'b0}, {1'b0, 1'b0, 8'd3, 1'b0}, {1'b1, 1'b0, 8'd5,  1'b0}
  };

  logic m_half = 1'b0, m_slow = 1'b0, m_mark = 1'b0;
  int   m_pos = 3, m_per = 4;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic e, input logic s);
    run = e; sel = s;
    @(posedge clk); #2;
  endtask

  task automatic model(input logic e, input logic s);
    logic nslow;
    if (e) begin
      if (m_pos == m_per - 1) begin m_pos = 0; m_per = s ? 6 : 4; end
      else m_pos++;
      nslow  = m_pos < m_per / 2;
      m_mark = !m_half && !m_slow && nslow;
      m_half = !m_half;
      m_slow = nslow;
    end else m_mark = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic h0, s0, prev_half, prev_slow;
    repeat (3) @(posedge clk);
    #2;
    chk(!half_clk && !slow_clk && !mark, "R8 reset state", {half_clk, slow_clk, mark}, 0);
    rst = 1'b0;

    foreach (SEG[i]) begin
      for (int c = 0; c < int'(SEG[i][8:1]); c++) begin
        prev_half = half_clk; prev_slow = slow_clk;
        step(SEG[i][10], SEG[i][9]);
        model(SEG[i][10], SEG[i][9]);
        chk(half_clk == m_half, SEG[i][10] ? "R1 half_clk" : "R5 half_clk hold", half_clk, m_half);
        chk(slow_clk == m_slow, !SEG[i][10] ? "R5 slow_clk hold" : (SEG[i][0] ? "R7 slow_clk" : "R2 slow_clk"),
            slow_clk, m_slow);
        chk(mark == m_mark, "R6 mark", mark, m_mark);
        if (!prev_slow && slow_clk)
          chk(!prev_half && half_clk, "R3 common rise", half_clk, 1);
      end
    end

    // R4: enable pulse wholly between two falling edges is ignored
    step(1'b0, 1'b0); step(1'b0, 1'b0);
    h0 = half_clk; s0 = slow_clk;
    #3 run = 1'b1;
    #2 run = 1'b0;
    @(posedge clk); #2;
    chk(half_clk == h0 && slow_clk == s0, "R4 short enable ignored", {half_clk, slow_clk}, {h0, s0});
    // R4: enable dropped after a falling edge still advances the next rising edge
    h0 = half_clk;
    run = 1'b1;
    @(negedge clk); #1 run = 1'b0;
    @(posedge clk); #2;
    chk(half_clk == !h0, "R4 late drop advances", half_clk, !h0);
    h0 = half_clk;
    @(posedge clk); #2;
    chk(half_clk == h0, "R5 stopped after drop", half_clk, h0);

    // R8: asynchronous reset clears outputs between edges
    run = 1'b1;
    @(posedge clk); #2;
    rst = 1'b1;
    #1;
    chk(!half_clk && !slow_clk && !mark, "R8 async clear", {half_clk, slow_clk, mark}, 0);
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    chk(!half_clk && !slow_clk && !mark, "R8 held in reset", {half_clk, slow_clk, mark}, 0);
    rst = 1'b0;
    step(1'b1, 1'b1);
    chk(half_clk && slow_clk && mark, "R8 first edge all high", {half_clk, slow_clk, mark}, 7);
    step(1'b1, 1'b1);
    chk(!half_clk && slow_clk && !mark, "R6 mark one period", {half_clk, slow_clk, mark}, 2);

    // R9: release with enable low keeps outputs low
    rst = 1'b1; run = 1'b0;
    step(1'b0, 1'b0);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b0);
      chk(!half_clk && !slow_clk && !mark, "R9 idle after reset", {half_clk, slow_clk, mark}, 0);
    end

    finish_run();
  end
endmodule